// File: doc/BRIEF.md
# Unicast Transmit Queue Manager

This block keeps the unicast transmit queues of a small switch fabric. Every queue holds frame control buffer handles, and there is one queue for each transmission class of each port. The queues are linked lists threaded through one shared next-pointer table indexed by handle. Each queue has its own head register, tail register and occupancy counter.

Standard ports have four classes and fast ports have eight. With the default parameters there are two standard ports and one fast port, which gives sixteen queues.

When a forwarding result arrives, the block first decides whether to admit or drop the frame. The frame is dropped if the global count of buffers in use is above a threshold, if the target queue is at its limit, or if the port number does not exist. A dropped handle is reported back at once, so that the buffer manager can reuse it. An admitted handle is appended to the tail of its queue.

When a port's transmit FIFO has room, the port asks for a handle. The block then removes the head entry of that port's highest-numbered non-empty class queue. A release strobe, sent once a frame has been transmitted, returns one buffer to the global count.

Top module: `ucast_txq`

## Requirements
- R1: After reset, `dropValid` and `rspValid` are 0 and every queue is empty. A handle request to any port gives a response with `rspHit`=0.
- R2: Ports 0 to NUM_STD_PORTS-1 have four classes, and the class is `enqPrio[2:1]`. Ports NUM_STD_PORTS to NUM_PORTS-1 have eight classes, and the class is `enqPrio` itself. `rspClass` reports the class that was served (0 to 3 or 0 to 7).
- R3: Within one queue, handles leave in the order in which they were admitted.
- R4: A request for port p serves the non-empty class of port p with the highest class number. Queues of other ports are not changed.
- R5: Every cycle with `deqReq`=1 is followed one cycle later by `rspValid`=1, and no other cycle has `rspValid`=1. `rspHit`=1 carries `rspHandle` and `rspClass`. `rspHit`=0 means every class of the port was empty.
- R6: An enqueue aimed at a queue that already holds QUEUE_LIMIT handles is dropped. The next cycle shows `dropValid`=1 with that handle, and the queue contents do not change. `dropValid` never rises without an enqueue in the cycle before.
- R7: The used-buffer count rises by 1 for each admitted handle and falls by 1 for each `relValid` pulse. A release does not take the count below zero. An enqueue is dropped when the count is above USED_THRESH in the cycle in which the enqueue is presented.
- R8: An enqueue to a port number of NUM_PORTS or more is dropped. A request for such a port answers `rspHit`=0.
- R9: An enqueue and a request presented in the same cycle both take effect. If the target queue is empty, the request misses and the handle stays queued. If the target queue holds one handle, that handle is served and the new handle becomes the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Forwarding result strobe |
| enqPort | input | PW | Destination port of the frame |
| enqPrio | input | 3 | Transmit priority of the frame |
| enqHandle | input | HW | Frame control buffer handle |
| dropValid | output | 1 | Previous enqueue was dropped |
| dropHandle | output | HW | Handle of the dropped frame |
| deqReq | input | 1 | Port asks for the next handle |
| deqPort | input | PW | Requesting port |
| rspValid | output | 1 | Response to the previous request |
| rspHit | output | 1 | A handle was found |
| rspHandle | output | HW | Served handle |
| rspClass | output | 3 | Class the handle came from |
| relValid | input | 1 | One transmitted buffer released |

## Verification
The main function is exercised with three patterns. The first mixes priorities on one standard port, which separates strict-priority selection from arrival order and checks the two-bit class mapping. The second sends work to the fast port while a standard port is asked for a handle, which shows that ports stay isolated and that the full three-bit class is kept. The third fills one queue to its limit while the global count nears the threshold, which tells a per-queue drop apart from a global drop. Directed tests then check the reset state, that a release at zero does not wrap the count, and that an enqueue and a request in the same cycle on an empty queue and on a one-entry queue both behave correctly.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic link;     // append linkHandle to queue linkQ
    logic unlink;   // remove head of queue unlinkQ
    logic usedInc;  // one more buffer in use
    logic usedDec;  // one buffer released
  } qStrobe_t;
endpackage

// File: rtl/ucast_txq_dp.sv
module ucast_txq_dp
  import txq_pkg::*;
#(
  parameter int NUM_QUEUES  = 16,
  parameter int NUM_HANDLES = 32,
  parameter int HW          = 5,
  parameter int QW          = 4,
  parameter int CNTW        = 3,
  parameter int UW          = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  qStrobe_t        stb,
  input  logic [QW-1:0]   linkQ,
  input  logic [HW-1:0]   linkHandle,
  input  logic [QW-1:0]   unlinkQ,
  output logic [CNTW-1:0] qCount [NUM_QUEUES],
  output logic [HW-1:0]   qHead  [NUM_QUEUES],
  output logic [UW-1:0]   usedCount
);
  logic [HW-1:0]   headR [NUM_QUEUES];
  logic [HW-1:0]   tailR [NUM_QUEUES];
  logic [CNTW-1:0] cntR  [NUM_QUEUES];
  logic [HW-1:0]   nextR [NUM_HANDLES];
  logic [UW-1:0]   usedR;
  logic [NUM_QUEUES-1:0] lnkVec, unlVec;

  always_comb begin
    for (int q = 0; q < NUM_QUEUES; q++) begin
      lnkVec[q] = stb.link   && (linkQ   == QW'(q));
      unlVec[q] = stb.unlink && (unlinkQ == QW'(q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        headR[q] <= '0;
        tailR[q] <= '0;
        cntR[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        if (unlVec[q])
          headR[q] <= (lnkVec[q] && cntR[q] == CNTW'(1)) ? linkHandle : nextR[headR[q]];
        else if (lnkVec[q] && cntR[q] == '0)
          headR[q] <= linkHandle;
        if (lnkVec[q])
          tailR[q] <= linkHandle;
        if (lnkVec[q] && !unlVec[q])
          cntR[q] <= cntR[q] + CNTW'(1);
        else if (unlVec[q] && !lnkVec[q])
          cntR[q] <= cntR[q] - CNTW'(1);
      end
    end
  end

  // Shared next-pointer table, written only when appending behind a tail
  always_ff @(posedge clk) begin
    if (stb.link && cntR[linkQ] != '0)
      nextR[tailR[linkQ]] <= linkHandle;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      usedR <= '0;
    else if (stb.usedInc && !stb.usedDec)
      usedR <= usedR + UW'(1);
    else if (stb.usedDec && !stb.usedInc)
      usedR <= usedR - UW'(1);
  end

  assign qCount    = cntR;
  assign qHead     = headR;
  assign usedCount = usedR;
endmodule

// File: rtl/ucast_txq_ctrl.sv
module ucast_txq_ctrl
  import txq_pkg::*;
#(
  parameter int NUM_STD_PORTS  = 2,
  parameter int NUM_FAST_PORTS = 1,
  parameter int NUM_QUEUES     = 16,
  parameter int QUEUE_LIMIT    = 4,
  parameter int USED_THRESH    = 6,
  parameter int HW             = 5,
  parameter int PW             = 2,
  parameter int QW             = 4,
  parameter int CNTW           = 3,
  parameter int UW             = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enqValid,
  input  logic [PW-1:0]   enqPort,
  input  logic [2:0]      enqPrio,
  input  logic [HW-1:0]   enqHandle,
  input  logic            deqReq,
  input  logic [PW-1:0]   deqPort,
  input  logic            relValid,
  input  logic [CNTW-1:0] qCount [NUM_QUEUES],
  input  logic [HW-1:0]   qHead  [NUM_QUEUES],
  input  logic [UW-1:0]   usedCount,
  output qStrobe_t        stb,
  output logic [QW-1:0]   linkQ,
  output logic [HW-1:0]   linkHandle,
  output logic [QW-1:0]   unlinkQ,
  output logic            dropValid,
  output logic [HW-1:0]   dropHandle,
  output logic            rspValid,
  output logic            rspHit,
  output logic [HW-1:0]   rspHandle,
  output logic [2:0]      rspClass
);
  localparam int NUM_PORTS = NUM_STD_PORTS + NUM_FAST_PORTS;
  localparam int STD_CLS   = 4;
  localparam int FAST_CLS  = 8;
  localparam int FAST_BASE = NUM_STD_PORTS * STD_CLS;

  logic enqPortOk, admit, deqPortOk, found, hit;
  int   enqIdx, deqBase, deqCls, selC;

  // Admission
  always_comb begin
    enqPortOk = 1'b1;
    enqIdx    = 0;
    if (int'(enqPort) < NUM_STD_PORTS)
      enqIdx = int'(enqPort) * STD_CLS + int'(enqPrio[2:1]);
    else if (int'(enqPort) < NUM_PORTS)
      enqIdx = FAST_BASE + (int'(enqPort) - NUM_STD_PORTS) * FAST_CLS + int'(enqPrio);
    else
      enqPortOk = 1'b0;
    admit = enqValid && enqPortOk
         && (qCount[QW'(enqIdx)] != CNTW'(QUEUE_LIMIT))
         && !(usedCount > UW'(USED_THRESH));
  end

  // Strict-priority head-of-line selection, highest class wins
  always_comb begin
    deqPortOk = 1'b1;
    deqBase   = 0;
    deqCls    = STD_CLS;
    if (int'(deqPort) < NUM_STD_PORTS)
      deqBase = int'(deqPort) * STD_CLS;
    else if (int'(deqPort) < NUM_PORTS) begin
      deqBase = FAST_BASE + (int'(deqPort) - NUM_STD_PORTS) * FAST_CLS;
      deqCls  = FAST_CLS;
    end else
      deqPortOk = 1'b0;
    found = 1'b0;
    selC  = 0;
    for (int c = 0; c < FAST_CLS; c++) begin
      if (c < deqCls && qCount[QW'(deqBase + c)] != '0) begin
        found = 1'b1;
        selC  = c;
      end
    end
    hit = deqReq && deqPortOk && found;
  end

  always_comb begin
    stb.link    = admit;
    stb.unlink  = hit;
    stb.usedInc = admit;
    stb.usedDec = relValid && (usedCount != '0);
    linkQ       = QW'(enqIdx);
    linkHandle  = enqHandle;
    unlinkQ     = QW'(deqBase + selC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropValid  <= 1'b0;
      dropHandle <= '0;
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspHandle  <= '0;
      rspClass   <= '0;
    end else begin
      dropValid  <= enqValid && !admit;
      dropHandle <= enqHandle;
      rspValid   <= deqReq;
      rspHit     <= hit;
      rspHandle  <= hit ? qHead[unlinkQ] : '0;
      rspClass   <= hit ? 3'(selC) : 3'd0;
    end
  end
endmodule

// File: rtl/ucast_txq.sv
module ucast_txq
  import txq_pkg::*;
#(
  parameter int NUM_STD_PORTS  = 2,
  parameter int NUM_FAST_PORTS = 1,
  parameter int NUM_HANDLES    = 32,
  parameter int QUEUE_LIMIT    = 4,
  parameter int USED_THRESH    = 6,
  localparam int NUM_PORTS     = NUM_STD_PORTS + NUM_FAST_PORTS,
  localparam int NUM_QUEUES    = NUM_STD_PORTS * 4 + NUM_FAST_PORTS * 8,
  localparam int HW            = $clog2(NUM_HANDLES),
  localparam int PW            = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int QW            = $clog2(NUM_QUEUES),
  localparam int CNTW          = $clog2(QUEUE_LIMIT + 1),
  localparam int UW            = $clog2(NUM_HANDLES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enqValid,
  input  logic [PW-1:0] enqPort,
  input  logic [2:0]    enqPrio,
  input  logic [HW-1:0] enqHandle,
  output logic          dropValid,
  output logic [HW-1:0] dropHandle,
  input  logic          deqReq,
  input  logic [PW-1:0] deqPort,
  output logic          rspValid,
  output logic          rspHit,
  output logic [HW-1:0] rspHandle,
  output logic [2:0]    rspClass,
  input  logic          relValid
);
  qStrobe_t        stb;
  logic [QW-1:0]   linkQ, unlinkQ;
  logic [HW-1:0]   linkHandle;
  logic [CNTW-1:0] qCount [NUM_QUEUES];
  logic [HW-1:0]   qHead  [NUM_QUEUES];
  logic [UW-1:0]   usedCount;

  ucast_txq_ctrl #(
    .NUM_STD_PORTS(NUM_STD_PORTS), .NUM_FAST_PORTS(NUM_FAST_PORTS),
    .NUM_QUEUES(NUM_QUEUES), .QUEUE_LIMIT(QUEUE_LIMIT), .USED_THRESH(USED_THRESH),
    .HW(HW), .PW(PW), .QW(QW), .CNTW(CNTW), .UW(UW)
  ) u_ctrl (
    .clk, .rstN, .enqValid, .enqPort, .enqPrio, .enqHandle,
    .deqReq, .deqPort, .relValid, .qCount, .qHead, .usedCount,
    .stb, .linkQ, .linkHandle, .unlinkQ,
    .dropValid, .dropHandle, .rspValid, .rspHit, .rspHandle, .rspClass
  );

  ucast_txq_dp #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_HANDLES(NUM_HANDLES),
    .HW(HW), .QW(QW), .CNTW(CNTW), .UW(UW)
  ) u_dp (
    .clk, .rstN, .stb, .linkQ, .linkHandle, .unlinkQ,
    .qCount, .qHead, .usedCount
  );
endmodule

// File: rtl/ucast_txq_chk.sv
module ucast_txq_chk #(
  parameter int NUM_QUEUES  = 16,
  parameter int QUEUE_LIMIT = 4,
  parameter int USED_THRESH = 6,
  parameter int CNTW        = 3,
  parameter int UW          = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            enqValid,
  input logic            dropValid,
  input logic            deqReq,
  input logic            rspValid,
  input logic            rspHit,
  input logic [CNTW-1:0] qCount [NUM_QUEUES],
  input logic [UW-1:0]   usedCount
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    deqReq |=> rspValid); // R5
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !deqReq |=> !rspValid); // R5
  AST_HIT_IN_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid); // R5
  AST_DROP_NEEDS_ENQ: assert property (@(posedge clk) disable iff (!rstN)
    !enqValid |=> !dropValid); // R6
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    usedCount <= UW'(USED_THRESH + 1)); // R7

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      qCount[q] <= CNTW'(QUEUE_LIMIT)); // R6
  end
endmodule

bind ucast_txq ucast_txq_chk #(
  .NUM_QUEUES(NUM_QUEUES), .QUEUE_LIMIT(QUEUE_LIMIT), .USED_THRESH(USED_THRESH),
  .CNTW(CNTW), .UW(UW)
) u_chk (
  .clk(clk), .rstN(rstN), .enqValid(enqValid), .dropValid(dropValid),
  .deqReq(deqReq), .rspValid(rspValid), .rspHit(rspHit),
  .qCount(qCount), .usedCount(usedCount)
);

// File: tb/sim_ucast_txq.sv
`timescale 1ns/1ps
module sim_ucast_txq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enqValid = 1'b0, deqReq = 1'b0, relValid = 1'b0;
  logic [1:0] enqPort = '0, deqPort = '0;
  logic [2:0] enqPrio = '0;
  logic [4:0] enqHandle = '0;
  logic       dropValid, rspValid, rspHit;
  logic [4:0] dropHandle, rspHandle;
  logic [2:0] rspClass;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ucast_txq u0 (
    .clk, .rstN, .enqValid, .enqPort, .enqPrio, .enqHandle,
    .dropValid, .dropHandle, .deqReq, .deqPort,
    .rspValid, .rspHit, .rspHandle, .rspClass, .relValid
  );

  localparam logic [1:0] OP_ENQ = 2'd0, OP_DEQ = 2'd1, OP_REL = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] port;
    logic [2:0] prio;
    logic [4:0] hnd;
    logic       exp;   // ENQ: drop expected, DEQ: hit expected
    logic [4:0] expH;
    logic [2:0] expC;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{OP_ENQ, 2'd0, 3'd6, 5'd1,  1'b0, 5'd0,  3'd0, 4'd2}, // R2 prio 6 -> class 3
    '{OP_ENQ, 2'd0, 3'd1, 5'd2,  1'b0, 5'd0,  3'd0, 4'd2}, // R2 prio 1 -> class 0
    '{OP_ENQ, 2'd0, 3'd7, 5'd3,  1'b0, 5'd0,  3'd0, 4'd3},
    '{OP_DEQ, 2'd0, 3'd0, 5'd0,  1'b1, 5'd1,  3'd3, 4'd4}, // R4 class 3 first
    '{OP_DEQ, 2'd0, 3'd0, 5'd0,  1'b1, 5'd3,  3'd3, 4'd3}, // R3 order kept
    '{OP_DEQ, 2'd0, 3'd0, 5'd0,  1'b1, 5'd2,  3'd0, 4'd2},
    '{OP_DEQ, 2'd0, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd5}, // R5 empty port
    '{OP_ENQ, 2'd2, 3'd5, 5'd4,  1'b0, 5'd0,  3'd0, 4'd2},
    '{OP_ENQ, 2'd2, 3'd2, 5'd5,  1'b0, 5'd0,  3'd0, 4'd2},
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd4}, // R4 other port empty
    '{OP_DEQ, 2'd2, 3'd0, 5'd0,  1'b1, 5'd4,  3'd5, 4'd4}, // R2 fast port full class
    '{OP_DEQ, 2'd2, 3'd0, 5'd0,  1'b1, 5'd5,  3'd2, 4'd2},
    '{OP_ENQ, 2'd3, 3'd0, 5'd6,  1'b1, 5'd6,  3'd0, 4'd8}, // R8 bad port
    '{OP_DEQ, 2'd3, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd8},
    '{OP_REL, 2'd0, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd7},
    '{OP_REL, 2'd0, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd7},
    '{OP_REL, 2'd0, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd7}, // used = 2
    '{OP_ENQ, 2'd1, 3'd3, 5'd7,  1'b0, 5'd0,  3'd0, 4'd6},
    '{OP_ENQ, 2'd1, 3'd3, 5'd8,  1'b0, 5'd0,  3'd0, 4'd6},
    '{OP_ENQ, 2'd1, 3'd3, 5'd9,  1'b0, 5'd0,  3'd0, 4'd6},
    '{OP_ENQ, 2'd1, 3'd3, 5'd10, 1'b0, 5'd0,  3'd0, 4'd6}, // used = 6
    '{OP_ENQ, 2'd1, 3'd2, 5'd11, 1'b1, 5'd11, 3'd0, 4'd6}, // R6 queue full
    '{OP_ENQ, 2'd0, 3'd0, 5'd12, 1'b0, 5'd0,  3'd0, 4'd7}, // used 6 not above: admit
    '{OP_ENQ, 2'd2, 3'd0, 5'd13, 1'b1, 5'd13, 3'd0, 4'd7}, // R7 global drop
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b1, 5'd7,  3'd1, 4'd6},
    '{OP_REL, 2'd0, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd7},
    '{OP_ENQ, 2'd2, 3'd0, 5'd14, 1'b0, 5'd0,  3'd0, 4'd7},
    '{OP_DEQ, 2'd2, 3'd0, 5'd0,  1'b1, 5'd14, 3'd0, 4'd7}, // dropped 13 absent
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b1, 5'd8,  3'd1, 4'd3},
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b1, 5'd9,  3'd1, 4'd3},
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b1, 5'd10, 3'd1, 4'd3},
    '{OP_DEQ, 2'd1, 3'd0, 5'd0,  1'b0, 5'd0,  3'd0, 4'd6}, // dropped 11 absent
    '{OP_DEQ, 2'd0, 3'd0, 5'd0,  1'b1, 5'd12, 3'd0, 4'd2}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, sample at the next one
  task automatic step(input logic e, input logic d, input logic r,
                      input logic [1:0] ep, input logic [2:0] pr,
                      input logic [4:0] h, input logic [1:0] dp);
    @(negedge clk);
    enqValid = e; enqPort = ep; enqPrio = pr; enqHandle = h;
    deqReq = d; deqPort = dp; relValid = r;
    @(negedge clk);
    enqValid = 1'b0; deqReq = 1'b0; relValid = 1'b0;
  endtask

  task automatic expEnq(input string tag, input logic drop, input logic [4:0] h);
    check({tag, " dropValid"}, int'(dropValid), int'(drop));
    if (drop) check({tag, " dropHandle"}, int'(dropHandle), int'(h));
  endtask

  task automatic expDeq(input string tag, input logic hit, input logic [4:0] h, input logic [2:0] c);
    check({tag, " rspValid"}, int'(rspValid), 1);
    check({tag, " rspHit"}, int'(rspHit), int'(hit));
    if (hit) begin
      check({tag, " rspHandle"}, int'(rspHandle), int'(h));
      check({tag, " rspClass"}, int'(rspClass), int'(c));
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 dropValid after reset", int'(dropValid), 0);
    check("R1 rspValid after reset", int'(rspValid), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_ENQ: begin
          step(1'b1, 1'b0, 1'b0, VECS[i].port, VECS[i].prio, VECS[i].hnd, 2'd0);
          expEnq(tag, VECS[i].exp, VECS[i].expH);
        end
        OP_DEQ: begin
          step(1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, VECS[i].port);
          expDeq(tag, VECS[i].exp, VECS[i].expH, VECS[i].expC);
        end
        default: step(1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 5'd0, 2'd0);
      endcase
    end

    // R1: every queue empty after a fresh reset
    doReset();
    for (int p = 0; p < 3; p++) begin
      step(1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, 2'(p));
      expDeq("R1 empty after reset", 1'b0, 5'd0, 3'd0);
    end

    // R7: release at zero must not wrap; 7 admits then a drop
    step(1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 5'd0, 2'd0);
    step(1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 5'd0, 2'd0);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 1'b0, 2'd0, 3'(2 * k), 5'(k), 2'd0);
      expEnq("R7 admit after idle release", 1'b0, 5'd0);
    end
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 1'b0, 2'd1, 3'(2 * k), 5'(4 + k), 2'd0);
      expEnq("R7 admit after idle release", 1'b0, 5'd0);
    end
    step(1'b1, 1'b0, 1'b0, 2'd2, 3'd0, 5'd7, 2'd0);
    expEnq("R7 drop above threshold", 1'b1, 5'd7);

    // R9: enqueue and request together
    repeat (3) step(1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 5'd0, 2'd0);
    step(1'b1, 1'b1, 1'b0, 2'd2, 3'd7, 5'd20, 2'd2);
    expEnq("R9 empty-queue enqueue", 1'b0, 5'd0);
    expDeq("R9 empty-queue request", 1'b0, 5'd0, 3'd0);
    step(1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, 2'd2);
    expDeq("R9 handle kept", 1'b1, 5'd20, 3'd7);
    step(1'b1, 1'b0, 1'b0, 2'd2, 3'd7, 5'd21, 2'd0);
    step(1'b1, 1'b1, 1'b0, 2'd2, 3'd7, 5'd22, 2'd2);
    expDeq("R9 one-entry request", 1'b1, 5'd21, 3'd7);
    step(1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, 2'd2);
    expDeq("R9 new sole entry", 1'b1, 5'd22, 3'd7);
    step(1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, 2'd2);
    expDeq("R9 queue drained", 1'b0, 5'd0, 3'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule